// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a CPU-side memory port and a bus controller. It turns 32-bit CPU addresses that land in a fixed outbound region into 64-bit bus addresses. The region is cut into equal windows. The window size is a power of two, programmed as a log2 code counted in megabytes. Each window has its own 64-bit target base, held in a low/high register pair. Bit 0 of the low half is that window's enable. A global translate-enable bit in the control register gates every region access.

A second, 4 KB CPU aperture carries configuration accesses. It sits 0x1000 above the controller base. For these, the block does not translate. It passes through the offset inside the aperture, together with the bus, device, function and access-type fields taken from a packed setup register.

Software programs the block through a 32-bit register port. Each access produces one registered result, one clock after it is presented. The result is either a target address or an error.

Top module: `ob_window_xlat`

## Requirements
- R1: After reset, every register reads 0 and `res_valid` is 0.
- R2: The registers that hold the last value written are: control at 0x004, configuration setup at 0x008, window size at 0x030, window n low at 0x200+8n and window n high at 0x204+8n. Any other offset reads 0, and writes to it change nothing.
- R3: `res_valid` is high exactly one cycle after `acc_valid`. When it is low, every result output is 0.
- R4: For an access in the outbound region, the window index is (address − region base) >> (20 + code), where code is bits 4:0 of the window size register.
- R5: For an enabled window, the result is {high, low} with its low (20 + code) bits cleared, plus the remainder of the region offset below the window size. `res_err` is 0 and `res_cfg` is 0.
- R6: An access that selects a window whose low-register bit 0 is 0 gives `res_err` = 1.
- R7: While bit 1 of the control register is 0, every region access gives `res_err` = 1.
- R8: A region access whose window index is NUM_WIN or more gives `res_err` = 1.
- R9: An access inside the 4 KB configuration aperture gives `res_cfg` = 1 and `res_err` = 0, whatever the translate-enable. `res_addr` is the offset inside the aperture. The target fields come from the setup register: bus from bits 23:16, device from bits 12:8, function from bits 2:0, and the Type 1 flag from bit 24.
- R10: An access outside both the region and the aperture gives `res_err` = 1.
- R11: A register write and an access in the same cycle: the access sees the register contents from before the write.
- R12: Whenever `res_err` is 1, `res_addr` is 0, `res_cfg` is 0 and all target fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the register at `reg_addr` |
| acc_valid | input | 1 | CPU access present |
| acc_addr | input | 32 | CPU access address |
| res_valid | output | 1 | Result valid, one cycle after the access |
| res_err | output | 1 | Access could not be translated |
| res_cfg | output | 1 | Result is a configuration access |
| res_type1 | output | 1 | Configuration access is Type 1 |
| res_bus | output | 8 | Configuration target bus |
| res_dev | output | 5 | Configuration target device |
| res_fn | output | 3 | Configuration target function |
| res_addr | output | 64 | Bus address, or the offset inside the configuration aperture |

## Verification
The bench drives accesses at the exact first and last byte of a window and of the region. A design that rounds the index wrongly would switch windows one byte early or late. A design that compares the index against the region size instead of the window count would accept index 4 and beyond.

A window base with ones in its low bits, together with a high half of all ones, exposes a design that does not mask the alignment bits, or that drops a carry into the upper word.

The bench changes the size code between 1 MB and 32 MB to catch a hard-wired shift. It writes the control register in the same cycle as an access, which catches a design that applies the new value one cycle early. It also checks configuration accesses while translation is off, which catches a design that gates the aperture with the translate-enable.

// File: rtl/obw_pkg.sv
package obw_pkg;

  // Register port geometry and fixed offsets that software decodes.
  localparam int unsigned REG_AW      = 12;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned BUS_AW      = 64;
  localparam int unsigned CODE_W      = 5;
  localparam int unsigned MB_SHIFT    = 20;
  localparam int unsigned APT_LOG2    = 12;
  localparam logic [DATA_W-1:0] APT_OFFSET = 32'h0000_1000;

  localparam logic [REG_AW-1:0] OFS_CTRL   = 12'h004;
  localparam logic [REG_AW-1:0] OFS_CFGSET = 12'h008;
  localparam logic [REG_AW-1:0] OFS_WSIZE  = 12'h030;
  localparam logic [REG_AW-1:0] OFS_WIN0   = 12'h200;

  localparam int unsigned XLAT_EN_BIT = 1;
  localparam int unsigned TYPE1_BIT   = 24;

  typedef struct packed {
    logic       type1;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
  } cfg_tgt_t;

  // Field positions of the configuration setup word.
  function automatic cfg_tgt_t unpack_setup(input logic [DATA_W-1:0] w);
    cfg_tgt_t t;
    t.type1 = w[TYPE1_BIT];
    t.bus   = w[23:16];
    t.dev   = w[12:8];
    t.fn    = w[2:0];
    return t;
  endfunction

  // Shift amount of a window: megabyte unit plus the log2 code.
  function automatic logic [5:0] span_shift(input logic [CODE_W-1:0] code);
    return 6'(MB_SHIFT) + {1'b0, code};
  endfunction

  // Mask of the offset bits inside one window.
  function automatic logic [BUS_AW-1:0] span_mask(input logic [CODE_W-1:0] code);
    return (64'd1 << span_shift(code)) - 64'd1;
  endfunction

  // Window index of a region offset.
  function automatic logic [DATA_W-1:0] win_slot(input logic [DATA_W-1:0] off,
                                                 input logic [CODE_W-1:0] code);
    return off >> span_shift(code);
  endfunction

  // Aligned base plus remainder inside the window.
  function automatic logic [BUS_AW-1:0] retarget(input logic [BUS_AW-1:0] base,
                                                 input logic [DATA_W-1:0] off,
                                                 input logic [CODE_W-1:0] code);
    logic [BUS_AW-1:0] m;
    m = span_mask(code);
    return (base & ~m) + ({32'd0, off} & m);
  endfunction

endpackage

// File: rtl/obw_regfile.sv
module obw_regfile
  import obw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [REG_AW-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic                           xlat_en,
  output logic [CODE_W-1:0]              size_code,
  output cfg_tgt_t                       cfg_tgt,
  output logic [NUM_WIN-1:0][BUS_AW-1:0] win_base,
  output logic [NUM_WIN-1:0]             win_en
);

  logic [DATA_W-1:0] ctrl_q, cfgs_q, wsize_q;
  logic [NUM_WIN-1:0][DATA_W-1:0] lo_w, hi_w;

  wire wr_ctrl  = we && (addr == OFS_CTRL);
  wire wr_cfgs  = we && (addr == OFS_CFGSET);
  wire wr_wsize = we && (addr == OFS_WSIZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cfgs_q  <= '0;
      wsize_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= wdata;
      if (wr_cfgs)  cfgs_q  <= wdata;
      if (wr_wsize) wsize_q <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [DATA_W-1:0] lo_r, hi_r;
    wire wr_lo = we && (addr == OFS_WIN0 + REG_AW'(8 * g));
    wire wr_hi = we && (addr == OFS_WIN0 + REG_AW'(8 * g + 4));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_r <= '0;
        hi_r <= '0;
      end else begin
        if (wr_lo) lo_r <= wdata;
        if (wr_hi) hi_r <= wdata;
      end
    end
    assign lo_w[g]     = lo_r;
    assign hi_w[g]     = hi_r;
    assign win_base[g] = {hi_r, lo_r};
    assign win_en[g]   = lo_r[0];
  end

  always_comb begin
    rdata = '0;
    if (addr == OFS_CTRL)   rdata = ctrl_q;
    if (addr == OFS_CFGSET) rdata = cfgs_q;
    if (addr == OFS_WSIZE)  rdata = wsize_q;
    for (int k = 0; k < NUM_WIN; k++) begin
      if (addr == OFS_WIN0 + REG_AW'(8 * k))     rdata = lo_w[k];
      if (addr == OFS_WIN0 + REG_AW'(8 * k + 4)) rdata = hi_w[k];
    end
  end

  assign xlat_en   = ctrl_q[XLAT_EN_BIT];
  assign size_code = wsize_q[CODE_W-1:0];
  assign cfg_tgt   = unpack_setup(cfgs_q);

  // R2: a write lands in the addressed register; other registers hold.
  p_setup_written_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfgs |=> (cfgs_q == $past(wdata)));
  p_ctrl_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));

endmodule

// File: rtl/obw_xlate.sv
module obw_xlate
  import obw_pkg::*;
#(
  parameter int unsigned       NUM_WIN     = 4,
  parameter logic [DATA_W-1:0] REGION_BASE = 32'h5000_0000,
  parameter int unsigned       REGION_LOG2 = 28,
  parameter logic [DATA_W-1:0] APT_BASE    = 32'h2100_1000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           acc_valid,
  input  logic [DATA_W-1:0]              acc_addr,
  input  logic                           xlat_en,
  input  logic [CODE_W-1:0]              size_code,
  input  cfg_tgt_t                       cfg_tgt,
  input  logic [NUM_WIN-1:0][BUS_AW-1:0] win_base,
  input  logic [NUM_WIN-1:0]             win_en,
  output logic                           res_valid,
  output logic                           res_err,
  output logic                           res_cfg,
  output cfg_tgt_t                       res_tgt,
  output logic [BUS_AW-1:0]              res_addr
);

  localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  // Named decode events, shared by the datapath and the assertions.
  logic [DATA_W-1:0] reg_off, apt_off, slot;
  logic [IDX_W-1:0]  sel;
  logic              hit_region, hit_cfg, slot_ok, sel_en, win_ok;

  always_comb begin
    reg_off    = acc_addr - REGION_BASE;
    apt_off    = acc_addr - APT_BASE;
    hit_region = (acc_addr >= REGION_BASE) && ((reg_off >> REGION_LOG2) == '0);
    hit_cfg    = (acc_addr >= APT_BASE) && ((apt_off >> APT_LOG2) == '0);
    slot       = win_slot(reg_off, size_code);
    slot_ok    = slot < DATA_W'(NUM_WIN);
    sel        = slot[IDX_W-1:0];
    sel_en     = slot_ok && win_en[sel];
    win_ok     = hit_region && xlat_en && sel_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_cfg   <= 1'b0;
      res_tgt   <= '0;
      res_addr  <= '0;
    end else begin
      res_valid <= acc_valid;
      res_err   <= acc_valid && !(hit_cfg || win_ok);
      res_cfg   <= acc_valid && hit_cfg;
      res_tgt   <= (acc_valid && hit_cfg) ? cfg_tgt : '0;
      if (acc_valid && hit_cfg)
        res_addr <= BUS_AW'(apt_off);
      else if (acc_valid && win_ok)
        res_addr <= retarget(win_base[sel], reg_off, size_code);
      else
        res_addr <= '0;
    end
  end

  p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!res_valid && res_addr == '0 && !res_err));
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit_region && slot_ok && !win_en[sel]) |=> res_err);
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit_region && !xlat_en) |=> res_err);
  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit_region && !slot_ok) |=> res_err);
  p_aperture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit_cfg) |=> (res_cfg && !res_err));
  p_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !hit_region && !hit_cfg) |=> res_err);
  p_err_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (res_addr == '0 && !res_cfg && res_tgt == '0));

endmodule

// File: rtl/ob_window_xlat.sv
module ob_window_xlat
  import obw_pkg::*;
#(
  parameter int unsigned       NUM_WIN     = 4,
  parameter logic [DATA_W-1:0] REGION_BASE = 32'h5000_0000,
  parameter int unsigned       REGION_LOG2 = 28,
  parameter logic [DATA_W-1:0] CTRL_BASE   = 32'h2100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  output logic              res_valid,
  output logic              res_err,
  output logic              res_cfg,
  output logic              res_type1,
  output logic [7:0]        res_bus,
  output logic [4:0]        res_dev,
  output logic [2:0]        res_fn,
  output logic [63:0]       res_addr
);

  localparam logic [DATA_W-1:0] APT_BASE = CTRL_BASE + APT_OFFSET;

  logic                           xlat_en;
  logic [CODE_W-1:0]              size_code;
  cfg_tgt_t                       cfg_tgt, res_tgt;
  logic [NUM_WIN-1:0][BUS_AW-1:0] win_base;
  logic [NUM_WIN-1:0]             win_en;

  obw_regfile #(.NUM_WIN(NUM_WIN)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .xlat_en  (xlat_en),
    .size_code(size_code),
    .cfg_tgt  (cfg_tgt),
    .win_base (win_base),
    .win_en   (win_en)
  );

  obw_xlate #(
    .NUM_WIN    (NUM_WIN),
    .REGION_BASE(REGION_BASE),
    .REGION_LOG2(REGION_LOG2),
    .APT_BASE   (APT_BASE)
  ) i_xlate (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_addr (acc_addr),
    .xlat_en  (xlat_en),
    .size_code(size_code),
    .cfg_tgt  (cfg_tgt),
    .win_base (win_base),
    .win_en   (win_en),
    .res_valid(res_valid),
    .res_err  (res_err),
    .res_cfg  (res_cfg),
    .res_tgt  (res_tgt),
    .res_addr (res_addr)
  );

  assign res_type1 = res_tgt.type1;
  assign res_bus   = res_tgt.bus;
  assign res_dev   = res_tgt.dev;
  assign res_fn    = res_tgt.fn;

endmodule

// File: tb/test_ob_window_xlat.sv
module test_ob_window_xlat;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam logic [63:0] RB = 64'h5000_0000;
  localparam logic [63:0] RSPAN = 64'h1000_0000;
  localparam logic [63:0] CB = 64'h2100_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, acc_valid = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, acc_addr = 0, reg_rdata;
  logic res_valid, res_err, res_cfg, res_type1;
  logic [7:0] res_bus;
  logic [4:0] res_dev;
  logic [2:0] res_fn;
  logic [63:0] res_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ob_window_xlat i_ob_window_xlat (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .res_valid(res_valid), .res_err(res_err),
    .res_cfg(res_cfg), .res_type1(res_type1), .res_bus(res_bus),
    .res_dev(res_dev), .res_fn(res_fn), .res_addr(res_addr)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] m_ctrl = 0, m_cfg = 0, m_size = 0;
  logic [31:0] m_lo [NW];
  logic [31:0] m_hi [NW];
  logic e_valid = 0, e_err = 0, e_cfg = 0;
  logic [16:0] e_tgt = 0;
  logic [63:0] e_addr = 0;
  string e_tag = "R1";

  initial for (int i = 0; i < NW; i++) begin m_lo[i] = 0; m_hi[i] = 0; end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int r;
    if (a == 12'h004) return m_ctrl;
    if (a == 12'h008) return m_cfg;
    if (a == 12'h030) return m_size;
    if (a >= 12'h200 && a < 12'h200 + 12'(8 * NW)) begin
      r = int'(a) - 'h200;
      if (r % 8 == 0) return m_lo[r / 8];
      if (r % 8 == 4) return m_hi[r / 8];
    end
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model: expectation from state before this edge, then apply writes (R11).
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cfg = 0; m_size = 0;
      for (int i = 0; i < NW; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
      e_valid = 0; e_err = 0; e_cfg = 0; e_tgt = 0; e_addr = 0; e_tag = "R1";
    end else begin
      logic [63:0] a, off, wsz, idx, base;
      e_valid = acc_valid; e_err = 0; e_cfg = 0; e_tgt = 0; e_addr = 0; e_tag = "R3";
      a = {32'd0, acc_addr};
      if (acc_valid) begin
        if (a >= CB && a < CB + 64'd4096) begin
          e_cfg = 1; e_addr = a - CB; e_tag = "R9";
          e_tgt = {m_cfg[24], m_cfg[23:16], m_cfg[12:8], m_cfg[2:0]};
        end else if (a >= RB && a < RB + RSPAN) begin
          off = a - RB;
          wsz = 64'd1 << (20 + int'(m_size[4:0]));
          idx = off / wsz;
          if (!m_ctrl[1]) begin e_err = 1; e_tag = "R7 R12"; end
          else if (idx >= 64'(NW)) begin e_err = 1; e_tag = "R8 R12"; end
          else if (!m_lo[idx][0]) begin e_err = 1; e_tag = "R6 R12"; end
          else begin
            base = {m_hi[idx], m_lo[idx]};
            e_addr = (base / wsz) * wsz + (off % wsz);
            e_tag = "R4 R5";
          end
        end else begin e_err = 1; e_tag = "R10 R12"; end
      end
      if (reg_we) begin
        if (reg_addr == 12'h004) m_ctrl = reg_wdata;
        if (reg_addr == 12'h008) m_cfg = reg_wdata;
        if (reg_addr == 12'h030) m_size = reg_wdata;
        for (int i = 0; i < NW; i++) begin
          if (reg_addr == 12'h200 + 12'(8 * i)) m_lo[i] = reg_wdata;
          if (reg_addr == 12'h204 + 12'(8 * i)) m_hi[i] = reg_wdata;
        end
      end
    end
  end

  // Every-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(res_valid == e_valid && res_err == e_err && res_cfg == e_cfg,
            e_tag, {61'd0, res_valid, res_err, res_cfg}, {61'd0, e_valid, e_err, e_cfg});
      check(res_addr == e_addr, e_tag, res_addr, e_addr);
      check({res_type1, res_bus, res_dev, res_fn} == e_tgt, e_tag,
            64'({res_type1, res_bus, res_dev, res_fn}), 64'(e_tgt));
      check(reg_rdata == m_read(reg_addr), "R2", 64'(reg_rdata), 64'(m_read(reg_addr)));
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; tick(); reg_we = 0;
  endtask
  task automatic acc(input logic [63:0] a);
    acc_valid = 1; acc_addr = a[31:0]; tick(); acc_valid = 0;
  endtask
  task automatic both(input logic [11:0] ra, input logic [31:0] d, input logic [63:0] a);
    reg_we = 1; reg_addr = ra; reg_wdata = d; acc_valid = 1; acc_addr = a[31:0];
    tick(); reg_we = 0; acc_valid = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=hung exp=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1: reset contents
    foreach (i_addrs[k]) begin
      reg_addr = i_addrs[k];
      @(negedge clk);
      check(reg_rdata == 0, "R1", 64'(reg_rdata), 0);
      check(res_valid == 0, "R1", 64'(res_valid), 0);
      tick();
    end
    // Window setup, 8 MB windows
    wr(12'h030, 32'd3);
    wr(12'h200, 32'hA000_0001); wr(12'h204, 32'h0000_0012);
    wr(12'h208, 32'h0080_0001); wr(12'h20C, 32'h0000_0001);
    wr(12'h210, 32'hC000_0000); wr(12'h214, 32'h0000_0002);
    wr(12'h218, 32'hFFF0_0001); wr(12'h21C, 32'hFFFF_FFFF);
    acc(RB + 64'h10);                     // R7: translation off
    wr(12'h004, 32'h2);
    acc(RB + 64'h123);                    // R4 R5 window 0
    acc(RB + 64'h80_0000 + 64'h7F_FFFF);  // last byte of window 1
    acc(RB + 64'h100_0004);               // R6 disabled window 2
    acc(RB + 64'h180_0005);               // window 3, masked base
    acc(RB + 64'h200_0000);               // R8 index 4
    acc(RB + RSPAN - 1);                  // R8 last region byte
    acc(RB - 1);                          // R10 below
    acc(RB + RSPAN);                      // R10 above
    // R9 configuration aperture
    wr(12'h008, 32'h0123_0A05);
    acc(CB + 64'h44);
    acc(CB + 64'hFFF);
    acc(CB + 64'h1000);                   // R10 just past aperture
    wr(12'h004, 32'h0);
    acc(CB);                              // R9 independent of translate-enable
    // R4 with 1 MB and 32 MB windows
    wr(12'h004, 32'h2);
    wr(12'h030, 32'd0);
    acc(RB + 64'h30_0010);
    acc(RB + 64'h40_0000);                // R8 index 4 at 1 MB
    wr(12'h030, 32'd5);
    acc(RB + 64'h7F_FFFF);
    // R11: write and access in one cycle use the old state
    both(12'h004, 32'h0, RB + 64'h20);
    acc(RB + 64'h20);
    both(12'h004, 32'h2, RB + 64'h20);
    // R2: unmapped offsets keep nothing
    wr(12'h00C, 32'hDEAD_BEEF);
    wr(12'h201, 32'h1234_5678);
    wr(12'h200 + 12'(8 * NW), 32'h5555_5555);
    reg_addr = 12'h00C; tick();
    reg_addr = 12'h200 + 12'(8 * NW); tick();
    // Mixed random traffic
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      reg_we = 0; acc_valid = 0;
      if (sel < 3) begin
        reg_we = 1;
        case ($urandom_range(0, 3))
          0: begin reg_addr = 12'h030; reg_wdata = $urandom_range(0, 6); end
          1: begin reg_addr = 12'h004; reg_wdata = $urandom; end
          2: begin reg_addr = 12'h008; reg_wdata = $urandom; end
          default: begin reg_addr = 12'h200 + 12'($urandom_range(0, 8 * NW + 7)); reg_wdata = $urandom; end
        endcase
      end
      if (sel > 1) begin
        acc_valid = 1;
        case ($urandom_range(0, 3))
          0: acc_addr = 32'(CB) + $urandom_range(0, 4200);
          1: acc_addr = $urandom;
          default: acc_addr = 32'(RB) + $urandom_range(0, 32'h0400_0000);
        endcase
      end
      if (!reg_we) reg_addr = 12'h200 + 12'($urandom_range(0, 8 * NW));
      tick();
    end
    reg_we = 0; acc_valid = 0;
    tick(); tick();
    finish_up();
  end

  logic [11:0] i_addrs [6] = '{12'h004, 12'h008, 12'h030, 12'h200, 12'h204, 12'h21C};

endmodule